// File: doc/BRIEF.md
# Real-Time Clock Update Cycle Sequencer

This block runs the once-per-second update of a clock whose time and calendar are kept twice: an internal copy that always counts and a user-visible copy that software reads. A 1 Hz tick starts each cycle. The block raises an update-in-progress status bit and sends one increment strobe to the internal counters. After a fixed lead time, measured in ticks of a fast timebase, it pulses a copy-enable that moves the internal values into the user copy. The pulse is withheld while the freeze bit is set, and the counters still advance. When the update window closes, the status bit drops. In the same clock edge the block sets an update-ended flag, and it sets an alarm flag when the alarm bytes agree with the time bytes.

Software polls the status bit: while it reads low, the user copy cannot change for at least the lead time. Software can also take an interrupt, which is the OR of each flag gated by its enable. A single clear strobe drops both flags, and it stands in for a read of the flag register. The counter arithmetic and the register bus sit outside this block.

Top module: `rtc_upd_seq`

## Requirements
- R1: A `sec_tick` sampled high while `uip` is low starts a cycle. `uip` is high from the next clock, and `inc_strobe` is high for exactly that one clock.
- R2: `copy_en` pulses for a single clock, and only after `LEAD_TICKS` `fast_tick` pulses have been sampled while `uip` is high. It is never high while `uip` is low.
- R3: `uip` stays high until `UPD_TICKS` `fast_tick` pulses (lead plus transfer window) have been sampled, then falls.
- R4: If `freeze` is high in the clock where the lead time ends, `copy_en` stays low for that cycle. `inc_strobe` still pulses, so the internal count keeps advancing.
- R5: Once `freeze` returns to 0, the next cycle pulses `copy_en` again and reloads the user copy.
- R6: `upd_end_flag` is set in the same edge that drops `uip`.
- R7: `alarm_flag` is set at that edge only if every alarm byte equals its time byte or is don't-care. A byte is don't-care when bits 7:6 are 2'b11; bits 7:6 of 2'b10 are an ordinary value.
- R8: `irq` = (`alarm_flag` & `en_alarm`) | (`upd_end_flag` & `en_upd`).
- R9: A `flag_clr` pulse clears both flags from the next clock. A flag set in that same edge wins over the clear.
- R10: A `sec_tick` that arrives while `uip` is high is ignored. It neither restarts the cycle nor adds an increment.
- R11: After reset, `uip`, `inc_strobe`, `copy_en`, both flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-clock pulse at 1 Hz |
| fast_tick | input | 1 | One-clock pulse of the timebase that measures the lead and transfer windows |
| freeze | input | 1 | Holds the user copy when high |
| time_bytes | input | 8*N_BYTES | Time bytes from the internal counters, byte i at bits 8i+7:8i |
| alarm_bytes | input | 8*N_BYTES | Alarm bytes, same layout |
| en_alarm | input | 1 | Interrupt enable for the alarm flag |
| en_upd | input | 1 | Interrupt enable for the update-ended flag |
| flag_clr | input | 1 | Clears both flags |
| uip | output | 1 | Update in progress |
| inc_strobe | output | 1 | One-second increment to the internal counters |
| copy_en | output | 1 | Copy internal values into the user copy |
| alarm_flag | output | 1 | Alarm matched at the last update |
| upd_end_flag | output | 1 | An update cycle has finished |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch several relations on every clock:
- each increment and each copy is a single pulse inside a high `uip`;
- a copy never follows a sampled `freeze`;
- a falling `uip` always carries the update-ended flag;
- a clear with no update running empties the flags;
- a tick during a running update never produces an increment.

Other behaviour needs the bench scenarios, which count timebase pulses against the copy and the fall of `uip`:
- the exact lead and window lengths;
- the reload after the freeze is lifted;
- alarm matching with exact, mismatching and don't-care bytes;
- the interrupt under each combination of enables.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_XFER = 2'd2
  } upd_state_e;

  localparam logic [1:0] DC_MARK = 2'b11;

  // a byte agrees when equal, or when its two top bits mark it don't-care
  function automatic logic byte_agrees(input logic [7:0] alm, input logic [7:0] tim);
    return (alm[7:6] == DC_MARK) || (alm == tim);
  endfunction

endpackage

// File: rtl/rtc_upd_timer.sv
module rtc_upd_timer
  import rtc_upd_pkg::*;
#(
  parameter int LEAD_TICKS = 8,
  parameter int UPD_TICKS  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic fast_tick,
  input  logic freeze,
  output logic uip,
  output logic inc_strobe,
  output logic copy_en,
  output logic finish
);

  localparam int XFER_TICKS = UPD_TICKS - LEAD_TICKS;
  localparam int CW         = $clog2(UPD_TICKS + 1);
  localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD_TICKS - 1);
  localparam logic [CW-1:0] XFER_LAST = CW'(XFER_TICKS - 1);

  upd_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          lead_done;

  always_comb begin
    lead_done = (state_q == ST_LEAD) && fast_tick && (cnt_q == LEAD_LAST);
    finish    = (state_q == ST_XFER) && fast_tick && (cnt_q == XFER_LAST);
    uip       = (state_q != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      inc_strobe <= 1'b0;
      copy_en    <= 1'b0;
    end else begin
      inc_strobe <= 1'b0;
      copy_en    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (sec_tick) begin
            state_q    <= ST_LEAD;
            cnt_q      <= '0;
            inc_strobe <= 1'b1;
          end
        end
        ST_LEAD: begin
          if (lead_done) begin
            state_q <= ST_XFER;
            cnt_q   <= '0;
            copy_en <= ~freeze;
          end else if (fast_tick) begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_XFER: begin
          if (finish) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else if (fast_tick) begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: begin
          state_q <= ST_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_upd_pkg::*;
#(
  parameter int N_BYTES = 3
) (
  input  logic [8*N_BYTES-1:0] time_bytes,
  input  logic [8*N_BYTES-1:0] alarm_bytes,
  output logic                 all_agree
);

  logic [N_BYTES-1:0] hit;

  for (genvar gi = 0; gi < N_BYTES; gi++) begin : g_byte
    assign hit[gi] = byte_agrees(alarm_bytes[8*gi +: 8], time_bytes[8*gi +: 8]);
  end

  assign all_agree = &hit;

endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank (
  input  logic clk,
  input  logic rst_n,
  input  logic finish,
  input  logic match,
  input  logic flag_clr,
  input  logic en_alarm,
  input  logic en_upd,
  output logic alarm_flag,
  output logic upd_end_flag,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_flag   <= 1'b0;
      upd_end_flag <= 1'b0;
    end else begin
      upd_end_flag <= finish | (upd_end_flag & ~flag_clr);
      alarm_flag   <= (finish & match) | (alarm_flag & ~flag_clr);
    end
  end

  assign irq = (alarm_flag & en_alarm) | (upd_end_flag & en_upd);

endmodule

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq #(
  parameter int N_BYTES    = 3,
  parameter int LEAD_TICKS = 8,
  parameter int UPD_TICKS  = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sec_tick,
  input  logic                 fast_tick,
  input  logic                 freeze,
  input  logic [8*N_BYTES-1:0] time_bytes,
  input  logic [8*N_BYTES-1:0] alarm_bytes,
  input  logic                 en_alarm,
  input  logic                 en_upd,
  input  logic                 flag_clr,
  output logic                 uip,
  output logic                 inc_strobe,
  output logic                 copy_en,
  output logic                 alarm_flag,
  output logic                 upd_end_flag,
  output logic                 irq
);

  logic finish;
  logic match;

  rtc_upd_timer #(
    .LEAD_TICKS(LEAD_TICKS),
    .UPD_TICKS (UPD_TICKS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .fast_tick (fast_tick),
    .freeze    (freeze),
    .uip       (uip),
    .inc_strobe(inc_strobe),
    .copy_en   (copy_en),
    .finish    (finish)
  );

  rtc_alarm_match #(
    .N_BYTES(N_BYTES)
  ) u_match (
    .time_bytes (time_bytes),
    .alarm_bytes(alarm_bytes),
    .all_agree  (match)
  );

  rtc_flag_bank u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .finish      (finish),
    .match       (match),
    .flag_clr    (flag_clr),
    .en_alarm    (en_alarm),
    .en_upd      (en_upd),
    .alarm_flag  (alarm_flag),
    .upd_end_flag(upd_end_flag),
    .irq         (irq)
  );

endmodule

// File: rtl/rtc_upd_seq_chk.sv
module rtc_upd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sec_tick,
  input logic freeze,
  input logic flag_clr,
  input logic uip,
  input logic inc_strobe,
  input logic copy_en,
  input logic alarm_flag,
  input logic upd_end_flag,
  input logic irq
);

  // R1
  uip_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> $past(sec_tick));

  // R1
  inc_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc_strobe |-> $rose(uip));

  // R2
  copy_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_en |-> uip);

  // R2
  copy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_en |=> !copy_en);

  // R4
  copy_not_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_en |-> !$past(freeze));

  // R6
  end_flag_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uip) |-> upd_end_flag);

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_flag && !upd_end_flag) |-> !irq);

  // R9
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !uip) |=> (!upd_end_flag && !alarm_flag));

  // R10
  busy_tick_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && uip) |=> !inc_strobe);

endmodule

bind rtc_upd_seq rtc_upd_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sec_tick    (sec_tick),
  .freeze      (freeze),
  .flag_clr    (flag_clr),
  .uip         (uip),
  .inc_strobe  (inc_strobe),
  .copy_en     (copy_en),
  .alarm_flag  (alarm_flag),
  .upd_end_flag(upd_end_flag),
  .irq         (irq)
);

// File: tb/rtc_upd_seq_tb_top.sv
module rtc_upd_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NB   = 3;
  localparam int LEAD = 8;
  localparam int UPD  = 64;

  typedef struct packed {
    logic copy;
    logic alarm;
    logic irq;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sec_tick = 1'b0;
  logic          fast_tick = 1'b0;
  logic          freeze = 1'b0;
  logic [8*NB-1:0] time_bytes = '0;
  logic [8*NB-1:0] alarm_bytes = '0;
  logic          en_alarm = 1'b0;
  logic          en_upd = 1'b0;
  logic          flag_clr = 1'b0;
  logic          uip, inc_strobe, copy_en, alarm_flag, upd_end_flag, irq;

  int   checks = 0;
  int   failures = 0;
  bit   finished = 0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_upd_seq #(.N_BYTES(NB), .LEAD_TICKS(LEAD), .UPD_TICKS(UPD)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .fast_tick(fast_tick),
    .freeze(freeze), .time_bytes(time_bytes), .alarm_bytes(alarm_bytes),
    .en_alarm(en_alarm), .en_upd(en_upd), .flag_clr(flag_clr),
    .uip(uip), .inc_strobe(inc_strobe), .copy_en(copy_en),
    .alarm_flag(alarm_flag), .upd_end_flag(upd_end_flag), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  // timebase: one pulse every four clocks, changed away from both edges
  initial begin
    int div;
    div = 0;
    forever begin
      step();
      fast_tick = (div == 3);
      div = (div + 1) % 4;
    end
  end

  // monitor / scoreboard
  int ticks = 0;
  int incs = 0;
  int lead_at = -1;
  bit copy_seen = 0;
  bit prev_uip = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      ticks = 0; incs = 0; lead_at = -1; copy_seen = 0; prev_uip = 0;
    end else begin
      if (inc_strobe) incs++;
      if (copy_en) begin
        chk(!copy_seen, "R2 single copy pulse", 1, 0);
        copy_seen = 1;
        lead_at = ticks;
      end
      if (prev_uip && !uip) begin
        exp_t e;
        if (exp_q.size() == 0) begin
          chk(0, "R1 unexpected update cycle", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk(ticks == UPD, "R3 window length", ticks, UPD);
          chk(incs == 1, "R1/R10 increment count", incs, 1);
          chk(copy_seen == e.copy, "R2/R4/R5 copy presence", int'(copy_seen), int'(e.copy));
          if (e.copy) chk(lead_at == LEAD, "R2 lead length", lead_at, LEAD);
          chk(upd_end_flag == 1'b1, "R6 update-ended flag", int'(upd_end_flag), 1);
          chk(alarm_flag == e.alarm, "R7 alarm flag", int'(alarm_flag), int'(e.alarm));
          chk(irq == e.irq, "R8 irq", int'(irq), int'(e.irq));
        end
        ticks = 0; incs = 0; lead_at = -1; copy_seen = 0;
      end else if (uip && fast_tick) begin
        ticks++;
      end
      prev_uip = uip;
    end
  end

  function automatic bit exp_match(input logic [8*NB-1:0] a, input logic [8*NB-1:0] t);
    bit ok;
    ok = 1;
    for (int i = 0; i < NB; i++)
      if (!(a[8*i+7] && a[8*i+6]) && a[8*i +: 8] != t[8*i +: 8]) ok = 0;
    return ok;
  endfunction

  task automatic run_update(input bit frz, input logic [8*NB-1:0] alm,
                            input logic [8*NB-1:0] tim, input bit ea, input bit eu,
                            input bit extra_tick);
    exp_t e;
    step();
    freeze = frz; alarm_bytes = alm; time_bytes = tim; en_alarm = ea; en_upd = eu;
    e.copy  = !frz;
    e.alarm = exp_match(alm, tim);
    e.irq   = (e.alarm & ea) | eu;
    exp_q.push_back(e);
    step(); sec_tick = 1'b1;
    step(); sec_tick = 1'b0;
    if (extra_tick) begin
      for (int i = 0; i < 40; i++) step();
      sec_tick = 1'b1;   // R10: tick during a running update
      step(); sec_tick = 1'b0;
    end
    while (exp_q.size() != 0) step();
    for (int i = 0; i < 4; i++) step();
    if (extra_tick) chk(uip == 1'b0, "R10 no restart", int'(uip), 0);
    flag_clr = 1'b1;
    step(); flag_clr = 1'b0;
    @(negedge clk);
    chk(upd_end_flag == 1'b0 && alarm_flag == 1'b0, "R9 flags cleared",
        int'({alarm_flag, upd_end_flag}), 0);
    chk(irq == 1'b0, "R9 irq after clear", int'(irq), 0);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) step();
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(uip == 0 && inc_strobe == 0 && copy_en == 0, "R11 reset strobes",
        int'({uip, inc_strobe, copy_en}), 0);
    chk(alarm_flag == 0 && upd_end_flag == 0 && irq == 0, "R11 reset flags",
        int'({alarm_flag, upd_end_flag, irq}), 0);

    run_update(0, 24'h12_34_56, 24'h12_34_56, 1, 0, 0); // exact match, alarm irq only
    run_update(0, 24'h12_35_56, 24'h12_34_56, 1, 1, 0); // one byte differs
    run_update(0, 24'h12_34_C5, 24'h12_34_56, 0, 0, 0); // R7 don't-care byte, irq masked
    run_update(1, 24'h12_34_80, 24'h12_34_56, 1, 1, 0); // R4 frozen, 2'b10 is not don't-care
    run_update(0, 24'hFF_FF_FF, 24'h00_11_22, 1, 0, 0); // R5 reload after unfreeze, all don't-care
    run_update(0, 24'h00_00_00, 24'h00_00_01, 0, 1, 1); // R10 extra tick mid-cycle

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule